// File: doc/BRIEF.md
# Multi-Core Priority Interrupt Dispatcher

This block is an interrupt controller that doubles as the task scheduler of a multi-core system. Every source keeps a pending request, an enable, a priority and the index of the core it is routed to. A request can come from a hardware line or from software on any core. Software on one core can therefore start a task on another core simply by marking that task's source as pending. All sources and all cores share one priority space.

For each core, the block picks the enabled, pending source routed to that core that has the highest priority. It raises that core's interrupt only when this priority is strictly above the core's current execution priority. When the core accepts the interrupt, the block clears the source's request and raises the core's current priority to the source's priority. The old priority is pushed onto a small per-core stack. A return request from the core pops the stack and restores the previous level. Software can rewrite a source's enable, priority and routing at any time, and the next arbitration uses the new values.

Top module: `mcid_dispatch`

## Requirements
- R1: After reset, every request, enable, priority and routing field is zero, every core's current priority is zero, and every interrupt output is low.
- R2: A high bit on `hw_req` or `sw_set` marks the corresponding source pending, whatever core the source is routed to. `pending` shows the request bits.
- R3: For each core, only sources that are pending, enabled and routed to that core compete. The highest priority wins, and among equal priorities the lowest source index wins. `irq_vec` slice c carries the winner's index.
- R4: A core's `irq` bit is high only when its winner's priority is strictly greater than that core's current priority. A priority-0 source can never interrupt.
- R5: When `cfg_we` is high, the enable, priority and routing of source `cfg_sel` are written. A disabled source stays pending but never wins. Changes are used by the next arbitration.
- R6: A request input changes `pending` at the next clock edge. `irq` and `irq_vec` reflect that change one edge later.
- R7: An `ack` bit that arrives while that core's `irq` is high clears the winning source's request. It also loads the core's current priority with the winner's priority and pushes the old value. The core's `irq` is low in the cycle after the acknowledge and is re-arbitrated on the next edge.
- R8: A `ret` bit restores the most recently pushed priority. The block ignores a return on an empty stack. It also ignores an acknowledge while `irq` is low, or while the stack already holds `STACK_DEPTH` entries: the request stays pending and the current priority is unchanged. When an acknowledge is accepted in the same cycle as a return, the return is ignored.
- R9: When a request is set and cleared in the same cycle, it ends up set. `sw_clr` clears a request only when no set is present for that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | NUM_SRC | Hardware request lines, one per source |
| sw_set | input | NUM_SRC | Software activation, one per source |
| sw_clr | input | NUM_SRC | Software withdrawal of a request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SRC_W | Source selected for configuration |
| cfg_en | input | 1 | Enable value to write |
| cfg_prio | input | PRIO_W | Priority value to write |
| cfg_core | input | CORE_W | Destination core to write |
| ack | input | NUM_CORE | Per-core interrupt acceptance |
| ret | input | NUM_CORE | Per-core return from handler |
| irq | output | NUM_CORE | Per-core interrupt request |
| irq_vec | output | NUM_CORE*SRC_W | Per-core winning source index, core c at bits c*SRC_W |
| cur_prio | output | NUM_CORE*PRIO_W | Per-core current execution priority |
| pending | output | NUM_SRC | Request bit of every source |

## Verification
On every cycle, the assertions check that a raised interrupt comes from a source that was a valid, routed candidate and that its priority exceeds the core's current priority. They also check that a set always beats a clear, that acknowledged requests are removed, that an accepted acknowledge loads the winner's priority, and that the stack never overflows. The tie-break toward the lower index, the one-edge latency, the effect of run-time priority and enable changes, and the restore order of nested priorities depend on particular request histories. Only the bench's scenarios can show these.

// File: rtl/mcid_pkg.sv
package mcid_pkg;
  // Operation applied to a core's priority stack in a given cycle.
  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/mcid_src_bank.sv
module mcid_src_bank #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 4,
  parameter int CORE_W  = 1,
  parameter int SRC_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         hw_req,
  input  logic [NUM_SRC-1:0]         sw_set,
  input  logic [NUM_SRC-1:0]         sw_clr,
  input  logic [NUM_SRC-1:0]         ack_clr,
  input  logic                       cfg_we,
  input  logic [SRC_W-1:0]           cfg_sel,
  input  logic                       cfg_en,
  input  logic [PRIO_W-1:0]          cfg_prio,
  input  logic [CORE_W-1:0]          cfg_core,
  output logic [NUM_SRC-1:0]         req_o,
  output logic [NUM_SRC-1:0]         en_o,
  output logic [NUM_SRC*PRIO_W-1:0]  prio_o,
  output logic [NUM_SRC*CORE_W-1:0]  core_o
);
  logic [NUM_SRC-1:0] set_any;
  logic [NUM_SRC-1:0] clr_any;

  // A set always dominates any clear arriving in the same cycle.
  function automatic logic [NUM_SRC-1:0] req_next(
    input logic [NUM_SRC-1:0] cur,
    input logic [NUM_SRC-1:0] set,
    input logic [NUM_SRC-1:0] clr
  );
    return set | (cur & ~clr);
  endfunction

  assign set_any = hw_req | sw_set;
  assign clr_any = sw_clr | ack_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o  <= '0;
      en_o   <= '0;
      prio_o <= '0;
      core_o <= '0;
    end else begin
      req_o <= req_next(req_o, set_any, clr_any);
      if (cfg_we) begin
        en_o[cfg_sel]                   <= cfg_en;
        prio_o[cfg_sel*PRIO_W +: PRIO_W] <= cfg_prio;
        core_o[cfg_sel*CORE_W +: CORE_W] <= cfg_core;
      end
    end
  end

  AST_SET_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_any) |=> ((req_o & $past(set_any)) == $past(set_any))); // R9

  AST_ACK_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_clr & ~set_any)) |=> ((req_o & $past(ack_clr & ~set_any)) == '0)); // R7
endmodule

// File: rtl/mcid_core_arb.sv
module mcid_core_arb #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 4,
  parameter int CORE_W  = 1,
  parameter int SRC_W   = 3,
  parameter int CORE_ID = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         req_i,
  input  logic [NUM_SRC-1:0]         en_i,
  input  logic [NUM_SRC*PRIO_W-1:0]  prio_i,
  input  logic [NUM_SRC*CORE_W-1:0]  core_i,
  input  logic [PRIO_W-1:0]          cur_prio_i,
  input  logic                       take_i,
  output logic                       irq_o,
  output logic [SRC_W-1:0]           vec_o,
  output logic [PRIO_W-1:0]          win_prio_o
);
  logic [NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0] cand_prev;
  logic               best_v;
  logic [SRC_W-1:0]   best_i;
  logic [PRIO_W-1:0]  best_p;

  // A newcomer replaces the best so far only when strictly higher;
  // scanning upward keeps the lower index on a tie.
  function automatic logic outranks(
    input logic              have,
    input logic [PRIO_W-1:0] p_new,
    input logic [PRIO_W-1:0] p_best
  );
    return !have || (p_new > p_best);
  endfunction

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cand
    assign cand[i] = req_i[i] & en_i[i] &
                     (core_i[i*CORE_W +: CORE_W] == CORE_W'(CORE_ID));
  end

  always_comb begin
    best_v = 1'b0;
    best_i = '0;
    best_p = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && outranks(best_v, prio_i[i*PRIO_W +: PRIO_W], best_p)) begin
        best_v = 1'b1;
        best_i = SRC_W'(i);
        best_p = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o      <= 1'b0;
      vec_o      <= '0;
      win_prio_o <= '0;
      cand_prev  <= '0;
    end else begin
      cand_prev  <= cand;
      vec_o      <= best_i;
      win_prio_o <= best_p;
      irq_o      <= take_i ? 1'b0 : (best_v && (best_p > cur_prio_i));
    end
  end

  AST_WINNER_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> cand_prev[vec_o]); // R3

  AST_ABOVE_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (win_prio_o > cur_prio_i)); // R4
endmodule

// File: rtl/mcid_prio_stack.sv
module mcid_prio_stack
  import mcid_pkg::*;
#(
  parameter int PRIO_W = 4,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_op_e           op_i,
  input  logic [PRIO_W-1:0] new_prio_i,
  output logic [PRIO_W-1:0] cur_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PRIO_W-1:0] mem [DEPTH];
  logic [SP_W-1:0]   sp;
  logic [IDX_W-1:0]  top_idx;

  assign full_o  = (sp == SP_W'(DEPTH));
  assign empty_o = (sp == '0);
  assign top_idx = IDX_W'(sp - SP_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp    <= '0;
      cur_o <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      case (op_i)
        STK_PUSH: if (!full_o) begin
          mem[IDX_W'(sp)] <= cur_o;
          sp              <= sp + SP_W'(1);
          cur_o           <= new_prio_i;
        end
        STK_POP: if (!empty_o) begin
          sp    <= sp - SP_W'(1);
          cur_o <= mem[top_idx];
        end
        default: ;
      endcase
    end
  end

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_W'(DEPTH)); // R8

  AST_PUSH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == STK_PUSH && !full_o) |=> (cur_o == $past(new_prio_i))); // R7
endmodule

// File: rtl/mcid_dispatch.sv
module mcid_dispatch
  import mcid_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int NUM_CORE    = 2,
  parameter int PRIO_W      = 4,
  parameter int STACK_DEPTH = 4,
  parameter int SRC_W       = (NUM_SRC  > 1) ? $clog2(NUM_SRC)  : 1,
  parameter int CORE_W      = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SRC-1:0]           hw_req,
  input  logic [NUM_SRC-1:0]           sw_set,
  input  logic [NUM_SRC-1:0]           sw_clr,
  input  logic                         cfg_we,
  input  logic [SRC_W-1:0]             cfg_sel,
  input  logic                         cfg_en,
  input  logic [PRIO_W-1:0]            cfg_prio,
  input  logic [CORE_W-1:0]            cfg_core,
  input  logic [NUM_CORE-1:0]          ack,
  input  logic [NUM_CORE-1:0]          ret,
  output logic [NUM_CORE-1:0]          irq,
  output logic [NUM_CORE*SRC_W-1:0]    irq_vec,
  output logic [NUM_CORE*PRIO_W-1:0]   cur_prio,
  output logic [NUM_SRC-1:0]           pending
);
  logic [NUM_SRC-1:0]        req_w;
  logic [NUM_SRC-1:0]        en_w;
  logic [NUM_SRC*PRIO_W-1:0] prio_w;
  logic [NUM_SRC*CORE_W-1:0] core_w;
  logic [NUM_SRC-1:0]        ack_clr;
  logic [NUM_CORE-1:0]       ack_ok;
  logic [NUM_CORE-1:0]       stk_full;
  logic [NUM_CORE-1:0]       stk_empty;
  logic [SRC_W-1:0]          vec_a  [NUM_CORE];
  logic [PRIO_W-1:0]         wprio_a[NUM_CORE];
  logic [PRIO_W-1:0]         cur_a  [NUM_CORE];
  stk_op_e                   op_a   [NUM_CORE];

  mcid_src_bank #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .CORE_W(CORE_W), .SRC_W(SRC_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .hw_req(hw_req), .sw_set(sw_set), .sw_clr(sw_clr), .ack_clr(ack_clr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
    .cfg_prio(cfg_prio), .cfg_core(cfg_core),
    .req_o(req_w), .en_o(en_w), .prio_o(prio_w), .core_o(core_w)
  );

  assign pending = req_w;

  // Acknowledged winners of all cores are withdrawn together.
  always_comb begin
    ack_clr = '0;
    for (int c = 0; c < NUM_CORE; c++) begin
      if (ack_ok[c]) ack_clr[vec_a[c]] = 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    // An acknowledge counts only against a live interrupt with stack room.
    assign ack_ok[c] = ack[c] & irq[c] & ~stk_full[c];
    assign op_a[c]   = ack_ok[c]                ? STK_PUSH :
                       (ret[c] && !stk_empty[c]) ? STK_POP  : STK_HOLD;

    mcid_core_arb #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .CORE_W(CORE_W),
      .SRC_W(SRC_W), .CORE_ID(c)
    ) u_arb (
      .clk(clk), .rst_n(rst_n),
      .req_i(req_w), .en_i(en_w), .prio_i(prio_w), .core_i(core_w),
      .cur_prio_i(cur_a[c]), .take_i(ack_ok[c]),
      .irq_o(irq[c]), .vec_o(vec_a[c]), .win_prio_o(wprio_a[c])
    );

    mcid_prio_stack #(
      .PRIO_W(PRIO_W), .DEPTH(STACK_DEPTH)
    ) u_stack (
      .clk(clk), .rst_n(rst_n),
      .op_i(op_a[c]), .new_prio_i(wprio_a[c]),
      .cur_o(cur_a[c]), .full_o(stk_full[c]), .empty_o(stk_empty[c])
    );

    assign irq_vec[c*SRC_W +: SRC_W]   = vec_a[c];
    assign cur_prio[c*PRIO_W +: PRIO_W] = cur_a[c];

    AST_REFUSED_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[c] && stk_full[c] && !ret[c]) |=> (cur_a[c] == $past(cur_a[c]))); // R8

    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ack_ok[c] |=> !irq[c]); // R7
  end
endmodule

// File: tb/mcid_dispatch_bench.sv
module mcid_dispatch_bench;
  localparam int NS = 8;
  localparam int NC = 2;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] hw_req = '0, sw_set = '0, sw_clr = '0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic          cfg_en = 1'b0;
  logic [PW-1:0] cfg_prio = '0;
  logic          cfg_core = 1'b0;
  logic [NC-1:0] ack = '0, ret = '0;
  logic [NC-1:0] irq;
  logic [5:0]    irq_vec;
  logic [7:0]    cur_prio;
  logic [NS-1:0] pending;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mcid_dispatch u_mcid_dispatch (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_set(sw_set), .sw_clr(sw_clr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en), .cfg_prio(cfg_prio),
    .cfg_core(cfg_core), .ack(ack), .ret(ret), .irq(irq), .irq_vec(irq_vec),
    .cur_prio(cur_prio), .pending(pending)
  );

  // Table step: {set[7:0], clr[7:0], irq[1:0], vec core0[2:0], vec core1[2:0]}
  localparam logic [23:0] STEPS [10] = '{
    {8'h01, 8'h00, 2'b01, 3'd0, 3'd0},
    {8'h80, 8'h00, 2'b11, 3'd0, 3'd7},
    {8'h10, 8'h00, 2'b11, 3'd4, 3'd7},
    {8'h04, 8'h00, 2'b11, 3'd2, 3'd7},
    {8'h0A, 8'h00, 2'b11, 3'd2, 3'd3},
    {8'h00, 8'h08, 2'b11, 3'd2, 3'd1},
    {8'h20, 8'h00, 2'b11, 3'd2, 3'd1},
    {8'h00, 8'h04, 2'b11, 3'd4, 3'd1},
    {8'h40, 8'h02, 2'b11, 3'd4, 3'd7},
    {8'h00, 8'h91, 2'b00, 3'd0, 3'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive_req(input logic [NS-1:0] s, input logic [NS-1:0] c);
    sw_set = s; sw_clr = c;
    @(negedge clk);
    sw_set = '0; sw_clr = '0;
  endtask

  task automatic do_cfg(input int sel, input logic en, input int prio, input int core);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_en = en;
    cfg_prio = PW'(prio); cfg_core = 1'(core);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_ack(input logic [NC-1:0] m);
    ack = m; @(negedge clk); ack = '0;
  endtask

  task automatic do_ret(input logic [NC-1:0] m);
    ret = m; @(negedge clk); ret = '0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    chk("R1 cur_prio", int'(cur_prio), 0);
    chk("R1 pending", int'(pending), 0);
    // R1 enables are cleared by reset: pending sources cannot interrupt
    drive_req(8'hFF, 8'h00);
    @(negedge clk);
    chk("R1 disabled after reset", int'(irq), 0);
    drive_req(8'h00, 8'hFF);

    do_cfg(0, 1'b1, 3, 0);
    do_cfg(1, 1'b1, 5, 1);
    do_cfg(2, 1'b1, 5, 0);
    do_cfg(3, 1'b1, 7, 1);
    do_cfg(4, 1'b1, 5, 0);
    do_cfg(5, 1'b0, 9, 0);
    do_cfg(6, 1'b1, 0, 1);
    do_cfg(7, 1'b1, 2, 1);

    // R3 R4 R5 table: routing, priority order, ties, disabled source
    for (int k = 0; k < 10; k++) begin
      drive_req(STEPS[k][23:16], STEPS[k][15:8]);
      @(negedge clk);
      chk($sformatf("R3 step %0d irq", k), int'(irq), int'(STEPS[k][7:6]));
      if (STEPS[k][6]) chk($sformatf("R3 step %0d vec0", k), int'(irq_vec[2:0]), int'(STEPS[k][5:3]));
      if (STEPS[k][7]) chk($sformatf("R3 step %0d vec1", k), int'(irq_vec[5:3]), int'(STEPS[k][2:0]));
    end
    // R5 disabled source 5 and R4 priority-0 source 6 stay pending
    chk("R5 pending after table", int'(pending), 8'h60);
    drive_req(8'h00, 8'hFF);

    // R2 hardware line sets a request
    hw_req = 8'h02; @(negedge clk); hw_req = '0;
    chk("R2 pending hw", int'(pending), 8'h02);
    @(negedge clk);
    chk("R2 irq core1", int'(irq[1]), 1);
    chk("R2 vec core1", int'(irq_vec[5:3]), 1);
    drive_req(8'h00, 8'hFF);
    @(negedge clk);

    // R6 one edge to pending, one more to irq
    drive_req(8'h01, 8'h00);
    chk("R6 pending first edge", int'(pending[0]), 1);
    chk("R6 irq not yet", int'(irq[0]), 0);
    @(negedge clk);
    chk("R6 irq second edge", int'(irq[0]), 1);
    drive_req(8'h00, 8'h01);

    // R9 set and clear together
    drive_req(8'h04, 8'h04);
    chk("R9 set wins", int'(pending[2]), 1);
    drive_req(8'h00, 8'h04);
    chk("R9 clear alone", int'(pending[2]), 0);
    @(negedge clk);

    // R7 acknowledge on core1
    drive_req(8'h0A, 8'h00);
    @(negedge clk);
    chk("R7 pre-ack vec1", int'(irq_vec[5:3]), 3);
    do_ack(2'b10);
    chk("R7 request cleared", int'(pending[3]), 0);
    chk("R7 cur_prio loaded", int'(cur_prio[7:4]), 7);
    chk("R7 irq drops", int'(irq[1]), 0);
    @(negedge clk);
    chk("R4 lower source blocked", int'(irq[1]), 0);
    // R5 run-time priority raise
    do_cfg(1, 1'b1, 8, 1);
    @(negedge clk);
    chk("R5 raised prio irq", int'(irq[1]), 1);
    chk("R5 raised prio vec", int'(irq_vec[5:3]), 1);
    do_ack(2'b10);
    chk("R7 nested load", int'(cur_prio[7:4]), 8);
    do_ret(2'b10);
    chk("R8 first restore", int'(cur_prio[7:4]), 7);
    do_ret(2'b10);
    chk("R8 second restore", int'(cur_prio[7:4]), 0);
    do_ret(2'b10);
    chk("R8 empty return ignored", int'(cur_prio[7:4]), 0);

    // R5 disabling a live source
    drive_req(8'h04, 8'h00);
    @(negedge clk);
    chk("R5 before disable", int'(irq[0]), 1);
    do_cfg(2, 1'b0, 5, 0);
    @(negedge clk);
    chk("R5 after disable", int'(irq[0]), 0);
    drive_req(8'h00, 8'hFF);

    // R8 stack full on core0
    for (int k = 0; k < 5; k++) do_cfg(k, 1'b1, k + 1, 0);
    for (int k = 0; k < 4; k++) begin
      drive_req(NS'(1) << k, 8'h00);
      @(negedge clk);
      chk("R7 nest vec0", int'(irq_vec[2:0]), k);
      do_ack(2'b01);
      chk("R7 nest cur0", int'(cur_prio[3:0]), k + 1);
    end
    drive_req(8'h10, 8'h00);
    @(negedge clk);
    chk("R8 fifth irq", int'(irq[0]), 1);
    do_ack(2'b01);
    chk("R8 full ack keeps request", int'(pending[4]), 1);
    chk("R8 full ack keeps prio", int'(cur_prio[3:0]), 4);
    do_ret(2'b01);
    chk("R8 pop restores", int'(cur_prio[3:0]), 3);
    @(negedge clk);
    chk("R8 still interrupting", int'(irq[0]), 1);
    chk("R8 still vec4", int'(irq_vec[2:0]), 4);

    // R8 acknowledge with no interrupt on core1
    do_ack(2'b10);
    chk("R8 idle ack ignored", int'(cur_prio[7:4]), 0);
    chk("R8 idle ack pending", int'(pending), 8'h10);

    done = 1'b1;
    report();
    $finish;
  end
endmodule